// File: doc/BRIEF.md
# Cascadable Loadable Binary Counter

This block is a synchronous binary up counter assembled from identical narrow counter slices. Each slice has a synchronous clear, a parallel load and a count enable. It also has a terminal-count output that is high while the slice is enabled and holding its all-ones value. The slices form a chain: the terminal count of each slice is the count enable of the slice above it. The chain therefore advances as one wide binary counter, and no adder spans the full width.

With the default parameters there are three 4-bit slices, giving a 12-bit counter. Reset and load are shared by every slice. The load value is split into one field per slice. The external count enable drives only the lowest slice. The terminal count of the top slice is brought out as the counter's terminal count, so two such counters can themselves be chained. The slice's incrementer is chosen by a parameter: either an explicit ripple of half adders, or a plain behavioural increment.

Top module: `cascade_counter`

## Requirements
- R1: At a rising clock edge with `rst` high, `count` becomes 0x000. This holds whatever `load_en` and `count_en` are.
- R2: At a rising clock edge with `rst` low and `load_en` high, `count` takes `load_val`, whatever `count_en` is. Bits [3:0] of `load_val` go to `count[3:0]`, bits [7:4] to `count[7:4]` and bits [11:8] to `count[11:8]`.
- R3: At a rising clock edge with `rst` and `load_en` low and `count_en` high, `count` increases by one, modulo 4096.
- R4: At a rising clock edge with `rst`, `load_en` and `count_en` all low, `count` keeps its value.
- R5: `term_cnt` is combinational. It is high in the same cycle exactly when `count_en` is high and `count` is 0xFFF, independent of `rst` and `load_en`.
- R6: With `count_en` high and no reset or load, a `count` of 0xFFF becomes 0x000 at the next edge.
- R7: An upper slice advances only in a cycle where every lower slice is all ones and `count_en` is high. For example, 0x00F goes to 0x010 and 0x0FF goes to 0x100, while other increments leave the upper slices unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, highest priority |
| load_en | input | 1 | Parallel load enable |
| load_val | input | 12 | Value taken on load |
| count_en | input | 1 | Count enable for the lowest slice |
| count | output | 12 | Current count |
| term_cnt | output | 1 | High when enabled at 0xFFF |

## Verification
The hardest case to reach from the ports is the carry that crosses both slice boundaries at once, 0xFFF to 0x000 with `term_cnt` high. Only one count in 4096 produces it. The stimulus reaches it two ways. First, loads place the counter just below each boundary (0x00E, 0x0FE, 0xFFE) and then count across it. Second, a free-running count starts from zero and walks through one complete wrap. Random reset, load and enable traffic then mixes the priorities at every possible count.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   // Variants available for the per-slice incrementer
   typedef enum logic [0:0] {
      INCR_RIPPLE = 1'b0,
      INCR_BEHAV  = 1'b1
   } incr_style_e;

   // Control bundle seen by one slice, in priority order
   typedef struct packed {
      logic clr;
      logic ld;
      logic en;
   } slice_ctl_t;

endpackage

// File: rtl/cnt_incr.sv
module cnt_incr #(
   parameter int W = 4,
   parameter cnt_pkg::incr_style_e STYLE = cnt_pkg::INCR_RIPPLE
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] s
);

   generate
      if (W < 1) begin : g_bad_w
         $error("cnt_incr: W must be at least 1");
      end

      if (STYLE == cnt_pkg::INCR_RIPPLE) begin : g_ripple
         logic [W-1:0] c;
         assign c[0] = 1'b1;
         for (genvar g = 0; g < W; g++) begin : g_bit
            assign s[g] = a[g] ^ c[g];
            if (g < W - 1) begin : g_carry
               assign c[g+1] = a[g] & c[g];
            end
         end
      end else begin : g_behav
         assign s = a + W'(1);
      end
   endgenerate

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice #(
   parameter int W = 4,
   parameter cnt_pkg::incr_style_e STYLE = cnt_pkg::INCR_RIPPLE
) (
   input  logic                clk,
   input  cnt_pkg::slice_ctl_t ctl,
   input  logic [W-1:0]        p,
   output logic [W-1:0]        q,
   output logic                tc
);

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] ZERO     = '0;

   logic [W-1:0] q_inc;
   logic [W-1:0] q_nxt;

   generate
      if (W < 1) begin : g_bad_w
         $error("cnt_slice: W must be at least 1");
      end
   endgenerate

   cnt_incr #(.W(W), .STYLE(STYLE)) u_incr (
      .a (q),
      .s (q_inc)
   );

   always_comb begin
      if (ctl.clr)      q_nxt = ZERO;
      else if (ctl.ld)  q_nxt = p;
      else if (ctl.en)  q_nxt = q_inc;
      else              q_nxt = q;
   end

   always_ff @(posedge clk) begin
      q <= q_nxt;
   end

   // Mealy terminal count: enabled and all ones
   assign tc = ctl.en & (&q);

   // R2: a load lands the parallel value
   a_r2_load_takes_p: assert property (@(posedge clk) disable iff (ctl.clr)
      ctl.ld |=> q == $past(p));

   // R3: counting adds one within the slice
   a_r3_slice_incr: assert property (@(posedge clk) disable iff (ctl.clr)
      (!ctl.ld && ctl.en) |=> q == W'($past(q) + W'(1)));

   // R4: idle slice holds
   a_r4_slice_hold: assert property (@(posedge clk) disable iff (ctl.clr)
      (!ctl.ld && !ctl.en) |=> $stable(q));

   // R6: a raised terminal count means the slice wraps to zero
   a_r6_slice_wrap: assert property (@(posedge clk) disable iff (ctl.clr)
      (tc && !ctl.ld) |=> q == ZERO);

   // R5: terminal count is never raised below the all-ones value
   a_r5_tc_only_at_max: assert property (@(posedge clk)
      (q != ALL_ONES) |-> !tc);

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
   parameter int SLICE_W    = 4,
   parameter int NUM_SLICES = 3,
   parameter cnt_pkg::incr_style_e STYLE = cnt_pkg::INCR_RIPPLE,
   localparam int CNT_W     = SLICE_W * NUM_SLICES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             count_en,
   output logic [CNT_W-1:0] count,
   output logic             term_cnt
);

   localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

   // en_chain[i] enables slice i; en_chain[i+1] is slice i's terminal count
   logic [NUM_SLICES:0] en_chain;

   generate
      if (SLICE_W < 1) begin : g_bad_slice_w
         $error("cascade_counter: SLICE_W must be at least 1");
      end
      if (NUM_SLICES < 1) begin : g_bad_num
         $error("cascade_counter: NUM_SLICES must be at least 1");
      end
   endgenerate

   assign en_chain[0] = count_en;

   generate
      for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
         cnt_pkg::slice_ctl_t ctl;
         assign ctl.clr = rst;
         assign ctl.ld  = load_en;
         assign ctl.en  = en_chain[i];

         cnt_slice #(.W(SLICE_W), .STYLE(STYLE)) u_slice (
            .clk (clk),
            .ctl (ctl),
            .p   (load_val[i*SLICE_W +: SLICE_W]),
            .q   (count[i*SLICE_W +: SLICE_W]),
            .tc  (en_chain[i+1])
         );
      end
   endgenerate

   assign term_cnt = en_chain[NUM_SLICES];

   // R1: reset clears the whole chain whatever else is asserted
   always_ff @(posedge clk) begin
      if ($past(rst)) begin
         a_r1_reset_clears: assert (count == '0);
      end
   end

   // R3: the chained slices behave as one wide incrementer
   a_r3_chain_incr: assert property (@(posedge clk) disable iff (rst)
      (count_en && !load_en) |=> count == CNT_W'($past(count) + CNT_W'(1)));

   // R6: top terminal count precedes a full wrap
   a_r6_chain_wrap: assert property (@(posedge clk) disable iff (rst)
      (term_cnt && !load_en) |=> count == '0);

   // R5: top terminal count implies enable and full count
   a_r5_term_needs_max: assert property (@(posedge clk)
      term_cnt |-> (count_en && count == MAX_CNT));

   // R7: upper slices do not move without a lower carry
   a_r7_upper_stable: assert property (@(posedge clk) disable iff (rst)
      (!load_en && !en_chain[1]) |=> $stable(count[CNT_W-1:SLICE_W]));

endmodule

// File: tb/cascade_counter_test.sv
`timescale 1ns/1ps
module cascade_counter_test;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_en = 1'b0;
   logic [W-1:0] load_val = '0;
   logic         count_en = 1'b0;
   logic [W-1:0] count;
   logic         term_cnt;

   int checks = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;

   item_t        sb[$];
   logic [W-1:0] model = '0;

   always #2 clk = ~clk;

   cascade_counter uut (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .load_val (load_val),
      .count_en (count_en),
      .count    (count),
      .term_cnt (term_cnt)
   );

   // Driver: applies one cycle of stimulus, checks the Mealy output, queues the next count
   task automatic step(input logic r, input logic l, input logic [W-1:0] p, input logic c);
      item_t it;
      logic  exp_tc;
      @(negedge clk);
      rst = r; load_en = l; load_val = p; count_en = c;
      #1;
      exp_tc = c && (model == 12'hFFF);
      checks++;
      if (term_cnt !== exp_tc) begin
         bad++;
         $display("FAIL R5 term_cnt actual=%0b expected=%0b count=%h", term_cnt, exp_tc, model);
      end
      if (r)                                it.tag = "R1";
      else if (l)                           it.tag = "R2";
      else if (c && model == 12'hFFF)       it.tag = "R6";
      else if (c && model[3:0] == 4'hF)     it.tag = "R7";
      else if (c)                           it.tag = "R3";
      else                                  it.tag = "R4";
      if (r)       model = '0;
      else if (l)  model = p;
      else if (c)  model = model + 12'd1;
      it.exp = model;
      sb.push_back(it);
   endtask

   // Monitor: after each edge, compares the count against the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (count !== it.exp) begin
               bad++;
               $display("FAIL %s count actual=%h expected=%h", it.tag, count, it.exp);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(4 * 150000);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset wins over load and count
      step(1, 1, 12'hABC, 1);
      step(1, 0, 12'h000, 0);
      // R2: load with and without count enable; field mapping
      step(0, 1, 12'h123, 0);
      step(0, 0, 12'h000, 0);          // R4 hold
      step(0, 1, 12'h9A5, 1);
      step(0, 0, 12'h000, 1);          // R3
      step(0, 0, 12'h000, 0);          // R4
      // R7: carry across the first boundary
      step(0, 1, 12'h00E, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 12'h000, 1);
      // R7: carry across both boundaries into slice 2
      step(0, 1, 12'h0FE, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 12'h000, 1);
      // R5/R6: wrap at the top with term_cnt high
      step(0, 1, 12'hFFE, 0);
      step(0, 0, 12'h000, 0);          // R5: at 0xFFE with enable low
      for (int i = 0; i < 3; i++) step(0, 0, 12'h000, 1);
      step(0, 1, 12'hFFF, 0);
      step(0, 0, 12'h000, 0);          // R5: 0xFFF, enable low, no term_cnt
      step(0, 1, 12'h555, 1);          // R2: load beats count at 0xFFF
      step(1, 0, 12'h000, 1);          // R1 from non-zero
      // R3/R6: complete free-running wrap
      for (int i = 0; i < 4100; i++) step(0, 0, 12'h000, 1);
      // Random mix of reset, load and enable
      for (int i = 0; i < 2000; i++) begin
         logic r, l, c;
         r = ($urandom_range(0, 49) == 0);
         l = ($urandom_range(0, 19) == 0);
         c = ($urandom_range(0, 3) != 0);
         step(r, l, W'($urandom_range(0, 4095)), c);
      end
      step(0, 0, 12'h000, 0);
      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule